// File: doc/BRIEF.md
# Scanline Display Timing Generator

This block paces a raster display. It cycles through three phases. In the draw phase a visible line is produced. In the horizontal-blank phase the beam returns between visible lines. The vertical-blank phase covers the lines below the visible area. The block keeps the number of the current scanline and a 16-bit status word.

The status word holds the blank and line-match flags, three interrupt enables and an 8-bit line compare value. Software writes this word to arm the enables and set the compare value. It reads the word back to see the flags. The block emits one-cycle interrupt request pulses on the following events:

- the start of each horizontal blank;
- the start of vertical blank;
- the moment the scanline reaches the programmed compare value.

The number of visible lines, the total line count and the lengths of the draw and horizontal-blank phases are parameters. The defaults are 160, 228, 960 and 272.

Phases and transitions:

- DRAW goes to HBLANK ("line done, visible") or to VBLANK ("line done, past visible").
- HBLANK goes to DRAW ("blank done").
- VBLANK stays in VBLANK ("blank line done") or goes to DRAW ("frame done").

Top module: `scanline_timer`

## Requirements
- R1: After reset the phase is DRAW, the scanline is 0, and all flags, enables, compare bits and interrupt outputs are 0.
- R2: Each DRAW phase lasts DRAW_CLKS cycles. On its last cycle the scanline counter increments.
- R3: When the new scanline is below VISIBLE_LINES, the phase becomes HBLANK and the hblank flag (status bit 1) is set. If hblank enable (status bit 4) is 1, irq_hblank pulses for one cycle. The flag, the pulse and the new scanline all appear in the same cycle.
- R4: Otherwise the phase becomes VBLANK and the vblank flag (status bit 0) is set. If vblank enable (status bit 3) is 1, irq_vblank pulses for one cycle in the same cycle.
- R5: HBLANK lasts BLANK_CLKS cycles and then returns to DRAW, clearing both the hblank and vblank flags.
- R6: In VBLANK every line lasts DRAW_CLKS+BLANK_CLKS cycles and the scanline increments at the end of each. After line TOTAL_LINES-1 the scanline returns to 0, the vblank flag clears and DRAW restarts.
- R7: The line-match flag (status bit 2) shows, one cycle later, whether the compare value (status bits 15:8) equalled the scanline.
- R8: irq_vcount pulses for a single cycle, in the cycle the line-match flag rises, and only if the line-match enable (status bit 5) is 1. A match that persists raises no further pulse.
- R9: A status write stores bits 5:3 and 15:8. Written values of bits 2:0 and 7:6 have no effect. Bits 7:6 read as 0.
- R10: One frame lasts VISIBLE_LINES*DRAW_CLKS + (VISIBLE_LINES-1)*BLANK_CLKS + (TOTAL_LINES-VISIBLE_LINES)*(DRAW_CLKS+BLANK_CLKS) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write data |
| stat_rdata | output | 16 | Status read data |
| scanline | output | 8 | Current scanline number |
| irq_hblank | output | 1 | Horizontal-blank interrupt pulse |
| irq_vblank | output | 1 | Vertical-blank interrupt pulse |
| irq_vcount | output | 1 | Line-match interrupt pulse |

## Verification
The bench uses short phase lengths so that it can cover many frames. It runs a long stretch of random status writes, with compare values mostly inside the line range. This separates wrong phase lengths, wrong flag clearing and wrong handling of write-only bits.

Directed cases cover the following:

- With only the vblank enable set, the spacing of the vblank pulses gives the frame length. This shows whether the skipped horizontal blank on the last visible line is handled correctly.
- A compare value held for a whole frame must produce exactly one line-match pulse. This separates edge detection from level detection.
- A compare value beyond the last line must produce none.

// File: rtl/scan_timer_pkg.sv
package scan_timer_pkg;
    localparam int LINE_W = 8;
    localparam int STAT_W = 16;

    // status bit positions
    localparam int ST_VBLANK    = 0;
    localparam int ST_HBLANK    = 1;
    localparam int ST_MATCH     = 2;
    localparam int ST_EN_VBLANK = 3;
    localparam int ST_EN_HBLANK = 4;
    localparam int ST_EN_MATCH  = 5;
    localparam int ST_CMP_LO    = 8;

    typedef enum logic [1:0] {
        PH_DRAW   = 2'd0,
        PH_HBLANK = 2'd1,
        PH_VBLANK = 2'd2
    } phase_e;
endpackage

// File: rtl/scan_dot_ctr.sv
module scan_dot_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              wrap,
    output logic [LINE_W-1:0] line
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line <= '0;
        else if (wrap)    line <= '0;
        else if (advance) line <= line + 1'b1;
    end
endmodule

// File: rtl/scan_status.sv
module scan_status
    import scan_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [LINE_W-1:0] line,
    input  logic              hb_flag,
    input  logic              vb_flag,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq_match
);
    logic [2:0]        en_q;
    logic [LINE_W-1:0] cmp_q;
    logic              match_q;
    logic              match_d;
    logic              unused_wbits;

    assign unused_wbits = ^{wr_data[7:6], wr_data[2:0]};
    assign match_d      = (cmp_q == line);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            cmp_q <= '0;
        end else if (wr_en) begin
            en_q  <= wr_data[ST_EN_MATCH:ST_EN_VBLANK];
            cmp_q <= wr_data[ST_CMP_LO +: LINE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q   <= 1'b0;
            irq_match <= 1'b0;
        end else begin
            match_q   <= match_d;
            irq_match <= en_q[2] && match_d && !match_q;
        end
    end

    always_comb begin
        rd_data                          = '0;
        rd_data[ST_VBLANK]               = vb_flag;
        rd_data[ST_HBLANK]               = hb_flag;
        rd_data[ST_MATCH]                = match_q;
        rd_data[ST_EN_MATCH:ST_EN_VBLANK] = en_q;
        rd_data[ST_CMP_LO +: LINE_W]     = cmp_q;
    end
endmodule

// File: rtl/scanline_timer.sv
module scanline_timer
    import scan_timer_pkg::*;
#(
    parameter int VISIBLE_LINES = 160,
    parameter int TOTAL_LINES   = 228,
    parameter int DRAW_CLKS     = 960,
    parameter int BLANK_CLKS    = 272
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stat_we,
    input  logic [15:0] stat_wdata,
    output logic [15:0] stat_rdata,
    output logic [7:0]  scanline,
    output logic        irq_hblank,
    output logic        irq_vblank,
    output logic        irq_vcount
);
    localparam int LINE_CLKS = DRAW_CLKS + BLANK_CLKS;
    localparam int CNT_W     = $clog2(LINE_CLKS);
    localparam logic [CNT_W-1:0]  DRAW_LAST  = CNT_W'(DRAW_CLKS - 1);
    localparam logic [CNT_W-1:0]  BLANK_LAST = CNT_W'(BLANK_CLKS - 1);
    localparam logic [CNT_W-1:0]  LINE_LAST  = CNT_W'(LINE_CLKS - 1);
    localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W:0]   VIS_LIMIT  = (LINE_W + 1)'(VISIBLE_LINES);

    phase_e            state_q, state_d;
    logic [CNT_W-1:0]  dot;
    logic [LINE_W-1:0] line;
    logic              end_draw, end_hblank, end_vblank;
    logic              next_visible, at_last_line;
    logic              hb_q, vb_q, irq_hb_q, irq_vb_q;

    scan_dot_ctr #(.CNT_W(CNT_W)) u_dot (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (end_draw | end_hblank | end_vblank),
        .cnt     (dot)
    );

    scan_line_ctr #(.LINE_W(LINE_W)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (end_draw | (end_vblank & ~at_last_line)),
        .wrap    (end_vblank & at_last_line),
        .line    (line)
    );

    scan_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (stat_we),
        .wr_data   (stat_wdata),
        .line      (line),
        .hb_flag   (hb_q),
        .vb_flag   (vb_q),
        .rd_data   (stat_rdata),
        .irq_match (irq_vcount)
    );

    assign end_draw     = (state_q == PH_DRAW)   && (dot == DRAW_LAST);
    assign end_hblank   = (state_q == PH_HBLANK) && (dot == BLANK_LAST);
    assign end_vblank   = (state_q == PH_VBLANK) && (dot == LINE_LAST);
    assign at_last_line = (line == LAST_LINE);
    assign next_visible = ({1'b0, line} + 1'b1) < VIS_LIMIT;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_DRAW;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_DRAW: begin
                if (end_draw) state_d = next_visible ? PH_HBLANK : PH_VBLANK;
            end
            PH_HBLANK: begin
                if (end_hblank) state_d = PH_DRAW;
            end
            PH_VBLANK: begin
                if (end_vblank && at_last_line) state_d = PH_DRAW;
            end
            default: state_d = PH_DRAW;
        endcase
    end

    // registered flags and interrupt pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_q     <= 1'b0;
            vb_q     <= 1'b0;
            irq_hb_q <= 1'b0;
            irq_vb_q <= 1'b0;
        end else begin
            irq_hb_q <= 1'b0;
            irq_vb_q <= 1'b0;
            unique case (state_q)
                PH_DRAW: begin
                    if (end_draw && next_visible) begin
                        hb_q     <= 1'b1;
                        irq_hb_q <= stat_rdata[ST_EN_HBLANK];
                    end else if (end_draw) begin
                        vb_q     <= 1'b1;
                        irq_vb_q <= stat_rdata[ST_EN_VBLANK];
                    end
                end
                PH_HBLANK: begin
                    if (end_hblank) begin
                        hb_q <= 1'b0;
                        vb_q <= 1'b0;
                    end
                end
                PH_VBLANK: begin
                    if (end_vblank && at_last_line) vb_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign scanline   = line;
    assign irq_hblank = irq_hb_q;
    assign irq_vblank = irq_vb_q;
endmodule

// File: rtl/scanline_timer_chk.sv
module scanline_timer_chk #(
    parameter int VISIBLE_LINES = 160,
    parameter int TOTAL_LINES   = 228
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] stat_rdata,
    input logic [7:0]  scanline,
    input logic        irq_hblank,
    input logic        irq_vblank,
    input logic        irq_vcount
);
    assert_hblank_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hblank |-> (stat_rdata[1] && $past(stat_rdata[4]) && scanline != $past(scanline)));

    assert_vblank_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |-> (stat_rdata[0] && scanline == 8'(VISIBLE_LINES)));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_rdata[0] && stat_rdata[1]));

    assert_line_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scanline < 8'(TOTAL_LINES));

    assert_match_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[2] |-> ($past(stat_rdata[15:8]) == $past(scanline)));

    assert_vcount_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vcount |-> $rose(stat_rdata[2]));

    assert_vcount_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vcount |=> !irq_vcount);
endmodule

bind scanline_timer scanline_timer_chk #(
    .VISIBLE_LINES (VISIBLE_LINES),
    .TOTAL_LINES   (TOTAL_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rdata (stat_rdata),
    .scanline   (scanline),
    .irq_hblank (irq_hblank),
    .irq_vblank (irq_vblank),
    .irq_vcount (irq_vcount)
);

// File: tb/scanline_timer_test.sv
`timescale 1ns/1ps
module scanline_timer_test;
    localparam int VIS   = 4;
    localparam int TOT   = 7;
    localparam int DRAW  = 6;
    localparam int BLANK = 3;
    localparam int LINE  = DRAW + BLANK;
    localparam int FRAME = VIS*DRAW + (VIS-1)*BLANK + (TOT-VIS)*LINE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stat_we = 1'b0;
    logic [15:0] stat_wdata = '0;
    logic [15:0] stat_rdata;
    logic [7:0]  scanline;
    logic        irq_hblank, irq_vblank, irq_vcount;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    scanline_timer #(.VISIBLE_LINES(VIS), .TOTAL_LINES(TOT),
                     .DRAW_CLKS(DRAW), .BLANK_CLKS(BLANK)) uut (
        .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .scanline(scanline),
        .irq_hblank(irq_hblank), .irq_vblank(irq_vblank), .irq_vcount(irq_vcount));

    // reference model, built from the requirements
    int       m_ph, m_dot, m_line;
    bit       m_hb, m_vb, m_match, m_ihb, m_ivb, m_ivc;
    bit [2:0] m_en;
    bit [7:0] m_cmp;

    function automatic logic [15:0] exp_status();
        return {m_cmp, 2'b00, m_en, m_match, m_hb, m_vb};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_dot = 0; m_line = 0; m_hb = 0; m_vb = 0; m_match = 0;
            m_ihb = 0; m_ivb = 0; m_ivc = 0; m_en = 0; m_cmp = 0;
        end else begin
            bit nm;
            nm      = (int'(m_cmp) == m_line);
            m_ivc   = m_en[2] && nm && !m_match;
            m_match = nm;
            m_ihb   = 0;
            m_ivb   = 0;
            case (m_ph)
                0: if (m_dot == DRAW-1) begin
                       m_dot = 0; m_line++;
                       if (m_line < VIS) begin m_ph = 1; m_hb = 1; m_ihb = m_en[1]; end
                       else begin m_ph = 2; m_vb = 1; m_ivb = m_en[0]; end
                   end else m_dot++;
                1: if (m_dot == BLANK-1) begin
                       m_dot = 0; m_ph = 0; m_hb = 0; m_vb = 0;
                   end else m_dot++;
                default: if (m_dot == LINE-1) begin
                       m_dot = 0;
                       if (m_line == TOT-1) begin m_line = 0; m_vb = 0; m_ph = 0; end
                       else m_line++;
                   end else m_dot++;
            endcase
            if (stat_we) begin
                m_en  = stat_wdata[5:3];
                m_cmp = stat_wdata[15:8];
            end
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare all outputs against the model after each edge
    task automatic compare_all();
        check("R2/R6", "scanline", 32'(scanline), 32'(m_line));
        check("R3/R5", "hblank flag", 32'(stat_rdata[1]), 32'(m_hb));
        check("R4/R6", "vblank flag", 32'(stat_rdata[0]), 32'(m_vb));
        check("R7", "match flag", 32'(stat_rdata[2]), 32'(m_match));
        check("R9", "status readback", 32'(stat_rdata), 32'(exp_status()));
        check("R3", "irq_hblank", 32'(irq_hblank), 32'(m_ihb));
        check("R4", "irq_vblank", 32'(irq_vblank), 32'(m_ivb));
        check("R8", "irq_vcount", 32'(irq_vcount), 32'(m_ivc));
    endtask

    task automatic tick(bit we = 0, logic [15:0] wd = '0);
        stat_we    = we;
        stat_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        stat_we = 0;
        compare_all();
    endtask

    initial begin
        int gap;
        int pulses;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset status", 32'(stat_rdata), 32'h0);
        check("R1", "reset scanline", 32'(scanline), 32'h0);
        check("R1", "reset irqs", 32'({irq_hblank, irq_vblank, irq_vcount}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // random writes mixed with idle cycles
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                logic [15:0] wd;
                wd = 16'($urandom);
                if ($urandom_range(0, 3) != 0) wd[15:8] = 8'($urandom_range(0, TOT));
                tick(1, wd);
            end else tick();
        end

        // R9: write-only-ignored bits, all ones in 7:6 and 2:0
        tick(1, 16'h00C7);
        check("R9", "ignored bits", 32'(stat_rdata[7:0] & 8'hC0), 32'h0);

        // R10: frame length from vblank pulse spacing
        tick(1, 16'h0008);
        gap = 0;
        while (!irq_vblank) tick();
        tick(); gap = 1;
        while (!irq_vblank) begin tick(); gap++; end
        check("R10", "frame cycles", 32'(gap), 32'(FRAME));

        // R8: held compare inside range gives one pulse per frame
        tick(1, 16'h0220);
        pulses = 0;
        for (int i = 0; i < FRAME; i++) begin tick(); if (irq_vcount) pulses++; end
        check("R8", "pulses per frame", 32'(pulses), 32'd1);

        // R8: compare beyond last line never matches
        tick(1, 16'hC820);
        pulses = 0;
        for (int i = 0; i < 2*FRAME; i++) begin tick(); if (irq_vcount) pulses++; end
        check("R8", "no-match pulses", 32'(pulses), 32'd0);

        // R3: hblank pulses per frame equal visible lines minus one
        tick(1, 16'h0010);
        pulses = 0;
        for (int i = 0; i < FRAME; i++) begin tick(); if (irq_hblank) pulses++; end
        check("R3", "hblank pulses per frame", 32'(pulses), 32'(VIS-1));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule